// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block drives a passive multiplexed liquid crystal panel with up to four common lines and thirty-two segment lines. A small display memory holds one bit per pixel. A mode register sets the duty (two, three or four commons), the bias (one third or one half), the scan clock source and a post-divider. While the panel is switched on, the block steps through the active commons. For every pin it outputs a two-bit level code that selects one tap of an external resistor ladder (code 0 = V0, 1 = V1, 2 = V2, 3 = V3). After each complete pass over the commons, the frame polarity flips so that no pixel sees a net DC voltage.

Segments 0 to 11 are always segment drivers. Segments 12 to 31 are handed over from general I/O in six groups, and each group has its own enable bit. The block reports which pins are segments on `seg_en`. A disabled segment pin always carries code 0.

Software reaches the block through a one-cycle write port. Address 0 to 15 is display memory. Address 16 is the mode register. Address 17 is the group enable register. Every other address is ignored.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset, all display memory, the mode register and the group enable register are zero. Every `com_lvl` and `seg_lvl` code is 0, and `seg_en` is 32'h0000_0FFF.
- R2: When mode bit 0 (enable) is 0, or when the duty field is 00, every common and every segment drives code 0 and the scan does not advance.
- R3: The duty field, mode bits [3:2], sets the number of active commons: 01 gives two, 10 gives three, 11 gives four. The common index steps 0,1,…,last and then returns to 0. Commons above the last active one drive code 0.
- R4: The frame polarity starts at 0 when the scan is enabled and toggles each time the common index wraps from the last active common back to 0.
- R5: At one-third bias (mode bit 1 = 0) with polarity 0, the selected common drives 3, an unselected common drives 1, a lit segment drives 0 and an unlit segment drives 2. With polarity 1 these levels are 0, 2, 3 and 1.
- R6: At one-half bias (mode bit 1 = 1), the selected common and a lit segment drive the same extremes as in R5. Unselected commons and unlit segments both drive 1, and code 2 never appears.
- R7: Segment s takes its pixel for common c from bit (s mod 2)·4 + c of memory byte s/2. A memory write is visible on the outputs in the cycle after the write edge.
- R8: Mode bit 6 selects the prescaler input. With 0, the prescaler counts `sub_tick` pulses and emits one pulse every SUB_DIV of them. With 1, it counts clock cycles and emits one pulse every MAIN_DIV of them. With bit 6 at 0 and `sub_tick` held low, the scan does not move.
- R9: Mode bits [5:4] divide the prescaler pulses by 1, 2, 4 or 8 (codes 00 to 11) before each common step.
- R10: Bits [5:0] of the group enable register release, in this order, segments 12–15, 16–17, 18–23, 24–25, 26 and 27–31. A segment whose bit is 0 has `seg_en` low and drives code 0.
- R11: Writes to addresses 18 to 31 change nothing observable. Bit 7 of a mode write is ignored.
- R12: Switching the enable off and on restarts the scan at common 0 with polarity 0 and a full step period ahead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| wr_en | input | 1 | Register/memory write strobe |
| wr_addr | input | 5 | Write address (0–15 memory, 16 mode, 17 group enables) |
| wr_data | input | 8 | Write data |
| com_lvl | output | 8 | Level code of common c at bits [2c+1:2c] |
| seg_lvl | output | 64 | Level code of segment s at bits [2s+1:2s] |
| seg_en | output | 32 | High where the pin works as a segment driver |

## Verification
The level codes are decoded in the same cycle from the index, polarity and memory registers. A fault in any of them therefore shows on the pins at once: a wrong memory byte or a wrong group bit appears in the cycle after the write. A stuck or skipping common index shows within one step period, because the selected common fails to move at the expected edge or moves early. A polarity register that does not flip shows at the first wrap, when every pin keeps its previous-frame level instead of swapping extremes. A prescaler or divider that is off by one count moves the step edge by one or more cycles, so the bench checks the cycle just before each expected step as well as the step cycle itself.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int SUB_DIV  = 32,
  parameter int MAIN_DIV = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_tick,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  com_lvl,
  output logic [63:0] seg_lvl,
  output logic [31:0] seg_en
);
  localparam int PMAX = (MAIN_DIV > SUB_DIV) ? MAIN_DIV : SUB_DIV;
  localparam int PW   = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam logic [PW-1:0] SUB_LIM  = PW'(SUB_DIV - 1);
  localparam logic [PW-1:0] MAIN_LIM = PW'(MAIN_DIV - 1);

  logic [7:0]    ram [16];
  logic [6:0]    mode;
  logic [5:0]    grp;
  logic [PW-1:0] pcnt;
  logic [2:0]    dcnt;
  logic [1:0]    cidx;
  logic          pol;
  logic [2:0]    dlim;

  wire       bias_half = mode[1];
  wire [1:0] duty      = mode[3:2];
  wire [1:0] div       = mode[5:4];
  wire       src_main  = mode[6];
  wire       on        = mode[0] && (duty != 2'd0);

  wire          src_tick = src_main ? 1'b1 : sub_tick;
  wire [PW-1:0] plim     = src_main ? MAIN_LIM : SUB_LIM;
  wire          lcdck    = on && src_tick && (pcnt >= plim);
  wire          scan     = lcdck && (dcnt >= dlim);

  always_comb begin
    case (div)
      2'd0:    dlim = 3'd0;
      2'd1:    dlim = 3'd1;
      2'd2:    dlim = 3'd3;
      default: dlim = 3'd7;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) ram[i] <= 8'd0;
      mode <= 7'd0;
      grp  <= 6'd0;
    end else if (wr_en) begin
      if (!wr_addr[4])          ram[wr_addr[3:0]] <= wr_data;
      else if (wr_addr == 5'd16) mode <= wr_data[6:0];
      else if (wr_addr == 5'd17) grp  <= wr_data[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= 3'd0;
      cidx <= 2'd0;
      pol  <= 1'b0;
    end else if (!on) begin
      pcnt <= '0;
      dcnt <= 3'd0;
      cidx <= 2'd0;
      pol  <= 1'b0;
    end else begin
      if (src_tick) pcnt <= lcdck ? '0 : pcnt + PW'(1);
      if (lcdck)    dcnt <= scan ? 3'd0 : dcnt + 3'd1;
      if (scan) begin
        if (cidx >= duty) begin
          cidx <= 2'd0;
          pol  <= ~pol;
        end else begin
          cidx <= cidx + 2'd1;
        end
      end
    end
  end

  wire [1:0] sel_lvl   = pol ? 2'd0 : 2'd3;
  wire [1:0] unsel_lvl = bias_half ? 2'd1 : (pol ? 2'd2 : 2'd1);
  wire [1:0] lit_lvl   = pol ? 2'd3 : 2'd0;
  wire [1:0] dark_lvl  = bias_half ? 2'd1 : (pol ? 2'd1 : 2'd2);

  for (genvar c = 0; c < 4; c++) begin : g_com
    assign com_lvl[2*c +: 2] = (!on || (2'(c) > duty)) ? 2'd0 :
                               (cidx == 2'(c)) ? sel_lvl : unsel_lvl;
  end

  for (genvar s = 0; s < 32; s++) begin : g_seg
    localparam int G = (s < 12) ? -1 : (s < 16) ? 0 : (s < 18) ? 1 :
                       (s < 24) ? 2 : (s < 26) ? 3 : (s < 27) ? 4 : 5;
    if (G < 0) begin : g_fixed
      assign seg_en[s] = 1'b1;
    end else begin : g_shared
      assign seg_en[s] = grp[G];
    end
    wire [3:0] nib = ram[s/2][(s%2)*4 +: 4];
    wire       lit = nib[cidx];
    assign seg_lvl[2*s +: 2] = (!on || !seg_en[s]) ? 2'd0 :
                               lit ? lit_lvl : dark_lvl;
  end
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [6:0]  mode,
  input logic [1:0]  cidx,
  input logic        pol,
  input logic        scan,
  input logic [7:0]  com_lvl,
  input logic [63:0] seg_lvl,
  input logic [31:0] seg_en
);
  logic        on;
  logic [3:0]  ext;
  logic [63:0] en_mask;
  logic        has2;

  assign on = mode[0] && (mode[3:2] != 2'd0);

  always_comb begin
    has2 = 1'b0;
    for (int c = 0; c < 4; c++) begin
      ext[c] = (2'(c) <= mode[3:2]) &&
               ((com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3));
      if (com_lvl[2*c +: 2] == 2'd2) has2 = 1'b1;
    end
    for (int s = 0; s < 32; s++) begin
      en_mask[2*s +: 2] = {2{seg_en[s]}};
      if (seg_lvl[2*s +: 2] == 2'd2) has2 = 1'b1;
    end
  end

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> (com_lvl == 8'd0 && seg_lvl == 64'd0));

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on |-> (cidx <= mode[3:2]));

  p_pol_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (on && scan && (cidx >= mode[3:2]) && !wr_en) |=> (pol != $past(pol)));

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on |-> ($countones(ext) == 1));

  p_half_no_v2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (on && mode[1]) |-> !has2);

  p_idle_seg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_lvl & ~en_mask) == 64'd0);

  p_fixed_seg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_en[11:0] == 12'hFFF);
endmodule

bind lcd_mux_seq lcd_mux_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode(mode), .cidx(cidx),
  .pol(pol), .scan(scan), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
  .seg_en(seg_en)
);

// File: tb/lcd_mux_seq_bench.sv
module lcd_mux_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = 5'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  com_lvl;
  logic [63:0] seg_lvl;
  logic [31:0] seg_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] ram_m [16];
  logic [5:0] grp_m = 6'd0;
  bit         bias_m = 1'b0;
  logic [1:0] duty_m = 2'd0;
  bit         on_m = 1'b0;

  lcd_mux_seq #(.SUB_DIV(4), .MAIN_DIV(16)) u_lcd_mux_seq (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .seg_en(seg_en)
  );

  always #5 clk = ~clk;

  function automatic int grp_of(int s);
    if (s < 16) return 0;
    if (s < 18) return 1;
    if (s < 24) return 2;
    if (s < 26) return 3;
    if (s < 27) return 4;
    return 5;
  endfunction

  function automatic logic [31:0] e_en();
    logic [31:0] v;
    for (int s = 0; s < 32; s++) v[s] = (s < 12) ? 1'b1 : grp_m[grp_of(s)];
    return v;
  endfunction

  function automatic logic [7:0] e_com(int idx, bit pol);
    logic [7:0] v = 8'd0;
    for (int c = 0; c < 4; c++) begin
      if (on_m && c <= int'(duty_m)) begin
        if (c == idx) v[2*c +: 2] = pol ? 2'd0 : 2'd3;
        else          v[2*c +: 2] = bias_m ? 2'd1 : (pol ? 2'd2 : 2'd1);
      end
    end
    return v;
  endfunction

  function automatic logic [63:0] e_seg(int idx, bit pol);
    logic [63:0] v = 64'd0;
    logic [31:0] en = e_en();
    for (int s = 0; s < 32; s++) begin
      if (on_m && en[s]) begin
        if (ram_m[s/2][(s%2)*4 + idx]) v[2*s +: 2] = pol ? 2'd3 : 2'd0;
        else v[2*s +: 2] = bias_m ? 2'd1 : (pol ? 2'd1 : 2'd2);
      end
    end
    return v;
  endfunction

  task automatic chk_lv(string rq, int idx, bit pol);
    logic [7:0]  ec = e_com(idx, pol);
    logic [63:0] es = e_seg(idx, pol);
    checks++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      errors++;
      $display("FAIL %s com=%h exp %h seg=%h exp %h", rq, com_lvl, ec, seg_lvl, es);
    end
  endtask

  task automatic chk_en(string rq);
    logic [31:0] ee = e_en();
    checks++;
    if (seg_en !== ee) begin
      errors++;
      $display("FAIL %s seg_en=%h exp %h", rq, seg_en, ee);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (a < 5'd16) ram_m[a[3:0]] = d;
    else if (a == 5'd16) begin
      on_m = d[0] && (d[3:2] != 2'd0);
      bias_m = d[1];
      duty_m = d[3:2];
    end else if (a == 5'd17) grp_m = d[5:0];
  endtask

  task automatic setmode(bit en, bit bias, logic [1:0] duty, logic [1:0] div, bit src);
    wr(5'd16, 8'd0);
    wr(5'd16, {1'b0, src, div, duty, bias, en});
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) ram_m[i] = 8'd0;
    chk_lv("R1 reset levels", 0, 0);
    chk_en("R1 reset seg_en");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) wr(5'(i), 8'((i * 37 + 11) ^ (i << 4)));
    wr(5'd17, 8'h3F);
    setmode(1, 0, 2'd3, 2'd3, 0);
    chk_lv("R7 memory map", 0, 0);
    wr(5'd3, 8'hA5);
    chk_lv("R7 write next cycle", 0, 0);
    wr(5'd20, 8'hFF);
    wr(5'd31, 8'h00);
    wr(5'd18, 8'h55);
    chk_lv("R11 unused addresses", 0, 0);
    chk_en("R11 unused addresses seg_en");
    wr(5'd16, 8'h80 | {1'b0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b1});
    chk_lv("R11 mode bit7 ignored", 0, 0);
  endtask

  task automatic t_duty(logic [1:0] duty, bit bias, string rq);
    int n = int'(duty) + 1;
    setmode(1, bias, duty, 2'd0, 0);
    for (int k = 0; k <= 2 * n; k++) begin
      chk_lv(rq, k % n, bit'((k / n) % 2));
      tick(4);
    end
  endtask

  task automatic t_div;
    for (int d = 0; d < 4; d++) begin
      int p = 4 << d;
      setmode(1, 0, 2'd3, 2'(d), 0);
      tick(p - 1);
      chk_lv("R9 before step", 0, 0);
      tick(1);
      chk_lv("R9 at step", 1, 0);
    end
  endtask

  task automatic t_src;
    sub_tick = 1'b0;
    setmode(1, 0, 2'd3, 2'd0, 1);
    tick(15);
    chk_lv("R8 main source before step", 0, 0);
    tick(1);
    chk_lv("R8 main source step", 1, 0);
    setmode(1, 0, 2'd3, 2'd0, 0);
    tick(40);
    chk_lv("R8 sub source idle", 0, 0);
    sub_tick = 1'b1;
    tick(3);
    chk_lv("R8 sub source before step", 0, 0);
    tick(1);
    chk_lv("R8 sub source step", 1, 0);
  endtask

  task automatic t_groups;
    setmode(1, 0, 2'd3, 2'd3, 0);
    for (int b = 0; b < 6; b++) begin
      wr(5'd17, 8'(1 << b));
      chk_en("R10 single group");
      chk_lv("R10 single group levels", 0, 0);
    end
    wr(5'd17, 8'h00);
    chk_en("R10 no groups");
    chk_lv("R10 no groups levels", 0, 0);
    wr(5'd17, 8'h3F);
    chk_en("R10 all groups");
  endtask

  task automatic t_off;
    setmode(0, 0, 2'd3, 2'd0, 0);
    chk_lv("R2 disabled", 0, 0);
    tick(20);
    chk_lv("R2 disabled stays off", 0, 0);
    setmode(1, 0, 2'd0, 2'd0, 0);
    chk_lv("R2 duty 00", 0, 0);
    tick(20);
    chk_lv("R2 duty 00 stays off", 0, 0);
  endtask

  task automatic t_restart;
    setmode(1, 0, 2'd3, 2'd0, 0);
    tick(20);
    chk_lv("R12 mid scan", 1, 1);
    setmode(1, 0, 2'd3, 2'd0, 0);
    chk_lv("R12 restart index", 0, 0);
    tick(3);
    chk_lv("R12 full period", 0, 0);
    tick(1);
    chk_lv("R12 first step", 1, 0);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
    t_reset();
    t_fill();
    t_duty(2'd1, 0, "R3 R4 R5 duty2");
    t_duty(2'd2, 0, "R3 R4 R5 duty3");
    t_duty(2'd3, 0, "R3 R4 R5 duty4");
    t_duty(2'd3, 1, "R6 half bias duty4");
    t_duty(2'd1, 1, "R6 half bias duty2");
    t_div();
    t_src();
    t_groups();
    t_off();
    t_restart();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_run();
    end
  end
endmodule